// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device. It runs the flash operations as hardware sequences, so software does not drive the command bytes itself. It supports four operations: a single-byte program, a block erase, an identifier check and a plain return to array-read mode.

A caller starts an operation with a one-cycle request that carries an opcode, an address and a data byte. The sequencer then works through the steps on its own:
- it writes the command bytes to the device;
- it polls the device status at a fixed spacing until the ready bit appears or a poll budget runs out;
- it judges the captured status with a mask chosen by the operation;
- it clears the device status without reporting on it, then waits for ready a second time;
- it puts the device back into array-read mode.

When the sequence ends, the block pulses `done` and presents a pass flag and a prioritised error code. A separate combinational port tells the caller whether a new byte can be programmed over an old one without an erase first.

Top module: `flash_prog_seq`

## Requirements
- R1: A program request (opcode 0) writes, at the request address, the bytes 0xFF, 0x40 and then the data byte, in that order.
- R2: An erase request (opcode 1) writes 0x20 and then 0xD0. Every write of the erase goes to the request address with its low BLOCK_AW bits forced to zero.
- R3: A status poll is a write of 0x70 followed in the next cycle by a read. Successive 0x70 writes are POLL_DIV+2 cycles apart. Polling stops when bit 7 of the read byte is set or after POLL_LIMIT reads.
- R4: A program passes exactly when status bits 4 and 3 are both clear. The other status bits have no effect on the result.
- R5: An erase passes when status bits 5 and 3 are both clear and bits 5 and 4 are not set together. Bit 4 set on its own still passes.
- R6: If the first poll ends without the ready bit, the operation fails with err_code 1 (timeout), whatever the other status bits show.
- R7: On a status failure, err_code takes the first match in this order. Bit 3 within the operation's mask gives 4. Bit 5 gives 3. Bit 4 gives 2. A masked status of zero gives 1. Anything else gives 5. A passing operation reports err_code 0.
- R8: After the evaluation, the block writes 0x50 and runs a second ready poll. The reported result is still the one judged before the clear.
- R9: Every operation ends with a write of 0xFF to its target address. `done` pulses for one cycle in the cycle that follows this write, and `busy` is low in the cycle after `done`.
- R10: An identifier check (opcode 2) writes 0x90 to the block base. It then reads the base and base+1. It passes only if these return 0x89 and 0xA2; otherwise err_code is 6.
- R11: `ovw_ok` is 1 exactly when (~ovw_old & ovw_new) is zero.
- R12: After reset, `busy`, `done`, `fl_we` and `fl_re` are low. `fl_we` and `fl_re` are never high together.
- R13: A read-mode request (opcode 3) issues only the single 0xFF write and reports a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_op | input | 2 | 0 program, 1 erase, 2 identifier check, 3 read mode |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | High from acceptance to the end of the done cycle |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation result, valid with done |
| err_code | output | 3 | Error code, valid with done |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write byte |
| fl_we | output | 1 | Flash write strobe, one cycle per byte |
| fl_re | output | 1 | Flash read strobe; fl_rdata sampled in the same cycle |
| fl_rdata | input | 8 | Flash read byte |
| ovw_old | input | 8 | Byte currently stored |
| ovw_new | input | 8 | Byte to be stored |
| ovw_ok | output | 1 | New byte reachable without erase |

## Verification
The bench targets the corner cases of the status masks.

- An erase that reports bit 4 alone must pass. A design that reused the program mask would fail it.
- A program that reports bit 5 must pass. A design that reused the erase mask would flag an error.
- An erase status with bits 5 and 4 both set must fail with the erase code.
- A status with Vpp low together with another error must report Vpp low. A design with a swapped priority chain would report the other code.

The bench also covers the poll loop:

- A device that never becomes ready must produce exactly POLL_LIMIT first-poll reads and the timeout code. An off-by-one counter would show up in the read count.
- After the 0x50 clear, the model reports only ready. A design that judged the second poll would turn every failure into a pass.

Finally, the bench checks the identifier path with a wrong manufacturer byte, and checks that the erase addresses are aligned to the block base.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

   typedef enum logic [1:0] {
      OP_PROG   = 2'd0,
      OP_ERASE  = 2'd1,
      OP_IDENT  = 2'd2,
      OP_RDMODE = 2'd3
   } flseq_op_e;

   typedef enum logic [2:0] {
      ERR_NONE    = 3'd0,
      ERR_TIMEOUT = 3'd1,
      ERR_WRITE   = 3'd2,
      ERR_ERASE   = 3'd3,
      ERR_VPP     = 3'd4,
      ERR_UNKNOWN = 3'd5,
      ERR_ID      = 3'd6
   } flseq_err_e;

   typedef enum logic [3:0] {
      S_IDLE, S_PRE_FF, S_CMD_A, S_CMD_B, S_PCMD, S_PRD, S_PWAIT,
      S_EVAL, S_CLR, S_ID_CMD, S_ID_RD0, S_ID_RD1, S_FIN_FF, S_DONE
   } flseq_state_e;

   localparam logic [7:0] CMD_ARRAY   = 8'hFF;
   localparam logic [7:0] CMD_PROG    = 8'h40;
   localparam logic [7:0] CMD_ERS_SET = 8'h20;
   localparam logic [7:0] CMD_ERS_GO  = 8'hD0;
   localparam logic [7:0] CMD_STAT    = 8'h70;
   localparam logic [7:0] CMD_CLEAR   = 8'h50;
   localparam logic [7:0] CMD_IDENT   = 8'h90;
   localparam logic [7:0] ID_MFR      = 8'h89;
   localparam logic [7:0] ID_DEV      = 8'hA2;

   localparam int ST_RDY = 7;

endpackage

// File: rtl/flseq_tick.sv
module flseq_tick #(
   parameter int DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CNTW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CNTW-1:0] LAST = CNTW'(DIV - 1);

   logic [CNTW-1:0] cnt_q;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("flseq_tick: DIV must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr)          cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick = !clr && (cnt_q == LAST);

endmodule

// File: rtl/flseq_eval.sv
module flseq_eval
   import flseq_pkg::*;
(
   input  logic       is_erase,
   input  logic       ready,
   input  logic [5:3] stat,
   output logic       ok,
   output logic [2:0] code
);
   logic [5:3] masked;
   logic       stat_ok;

   always_comb begin
      masked  = is_erase ? (stat & 3'b101) : (stat & 3'b011);
      stat_ok = (masked == 3'b000) && !(is_erase && stat[5] && stat[4]);
      if (!ready) begin
         ok   = 1'b0;
         code = ERR_TIMEOUT;
      end else if (stat_ok) begin
         ok   = 1'b1;
         code = ERR_NONE;
      end else begin
         ok = 1'b0;
         if (masked[3])           code = ERR_VPP;
         else if (masked[5])      code = ERR_ERASE;
         else if (masked[4])      code = ERR_WRITE;
         else if (masked == '0)   code = ERR_TIMEOUT;
         else                     code = ERR_UNKNOWN;
      end
   end

endmodule

// File: rtl/flseq_ovw.sv
module flseq_ovw #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] old_b,
   input  logic [DW-1:0] new_b,
   output logic          ok
);
   logic [DW-1:0] bit_ok;

   generate
      for (genvar i = 0; i < DW; i++) begin : g_bit
         assign bit_ok[i] = old_b[i] | ~new_b[i];
      end
   endgenerate

   assign ok = &bit_ok;

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
   import flseq_pkg::*;
#(
   parameter int AW         = 20,
   parameter int BLOCK_AW   = 16,
   parameter int POLL_DIV   = 50,
   parameter int POLL_LIMIT = 5000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic          busy,
   output logic          done,
   output logic          pass,
   output logic [2:0]    err_code,
   output logic [AW-1:0] fl_addr,
   output logic [7:0]    fl_wdata,
   output logic          fl_we,
   output logic          fl_re,
   input  logic [7:0]    fl_rdata,
   input  logic [7:0]    ovw_old,
   input  logic [7:0]    ovw_new,
   output logic          ovw_ok
);
   localparam int CW = $clog2(POLL_LIMIT + 1);
   localparam logic [CW-1:0] POLL_LAST = CW'(POLL_LIMIT - 1);
   localparam logic [AW-1:0] BLK_MASK  = {{(AW-BLOCK_AW){1'b1}}, {BLOCK_AW{1'b0}}};
   localparam logic [AW-1:0] ODD_OFS   = {{(AW-1){1'b0}}, 1'b1};

   generate
      if (AW < 2)                            begin : g_bad_aw
         $error("flash_prog_seq: AW too small");
      end
      if (BLOCK_AW < 1 || BLOCK_AW >= AW)     begin : g_bad_blk
         $error("flash_prog_seq: BLOCK_AW out of range");
      end
      if (POLL_LIMIT < 1)                     begin : g_bad_lim
         $error("flash_prog_seq: POLL_LIMIT must be positive");
      end
   endgenerate

   flseq_state_e  st_q;
   flseq_op_e     op_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic [CW-1:0] poll_cnt_q;
   logic          second_q;
   logic [5:3]    stat_q;
   logic          rdy_q;
   logic [7:0]    id0_q;
   logic          pass_q;
   logic [2:0]    err_q;

   logic          tick;
   logic          ev_ok;
   logic [2:0]    ev_code;
   logic          id_match;
   flseq_op_e     req_op_e;

   assign req_op_e = flseq_op_e'(req_op);
   assign id_match = (id0_q == ID_MFR) && (fl_rdata == ID_DEV);

   flseq_tick #(.DIV(POLL_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q != S_PWAIT),
      .tick  (tick)
   );

   flseq_eval u_eval (
      .is_erase (op_q == OP_ERASE),
      .ready    (rdy_q),
      .stat     (stat_q),
      .ok       (ev_ok),
      .code     (ev_code)
   );

   flseq_ovw #(.DW(8)) u_ovw (
      .old_b (ovw_old),
      .new_b (ovw_new),
      .ok    (ovw_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         op_q       <= OP_PROG;
         addr_q     <= '0;
         data_q     <= '0;
         poll_cnt_q <= '0;
         second_q   <= 1'b0;
         stat_q     <= '0;
         rdy_q      <= 1'b0;
         id0_q      <= '0;
         pass_q     <= 1'b0;
         err_q      <= ERR_NONE;
      end else begin
         case (st_q)
            S_IDLE: begin
               if (req_valid) begin
                  op_q       <= req_op_e;
                  addr_q     <= (req_op_e == OP_ERASE || req_op_e == OP_IDENT)
                                ? (req_addr & BLK_MASK) : req_addr;
                  data_q     <= req_data;
                  poll_cnt_q <= '0;
                  second_q   <= 1'b0;
                  pass_q     <= (req_op_e == OP_RDMODE);
                  err_q      <= ERR_NONE;
                  case (req_op_e)
                     OP_PROG:  st_q <= S_PRE_FF;
                     OP_ERASE: st_q <= S_CMD_A;
                     OP_IDENT: st_q <= S_ID_CMD;
                     default:  st_q <= S_FIN_FF;
                  endcase
               end
            end
            S_PRE_FF: st_q <= S_CMD_A;
            S_CMD_A:  st_q <= S_CMD_B;
            S_CMD_B:  st_q <= S_PCMD;
            S_PCMD:   st_q <= S_PRD;
            S_PRD: begin
               poll_cnt_q <= poll_cnt_q + 1'b1;
               if (fl_rdata[ST_RDY] || poll_cnt_q == POLL_LAST) begin
                  if (!second_q) begin
                     stat_q <= fl_rdata[5:3];
                     rdy_q  <= fl_rdata[ST_RDY];
                     st_q   <= S_EVAL;
                  end else begin
                     st_q   <= S_FIN_FF;
                  end
               end else begin
                  st_q <= S_PWAIT;
               end
            end
            S_PWAIT: if (tick) st_q <= S_PCMD;
            S_EVAL: begin
               pass_q <= ev_ok;
               err_q  <= ev_code;
               st_q   <= S_CLR;
            end
            S_CLR: begin
               second_q   <= 1'b1;
               poll_cnt_q <= '0;
               st_q       <= S_PCMD;
            end
            S_ID_CMD: st_q <= S_ID_RD0;
            S_ID_RD0: begin
               id0_q <= fl_rdata;
               st_q  <= S_ID_RD1;
            end
            S_ID_RD1: begin
               pass_q <= id_match;
               err_q  <= id_match ? ERR_NONE : ERR_ID;
               st_q   <= S_FIN_FF;
            end
            S_FIN_FF: st_q <= S_DONE;
            S_DONE:   st_q <= S_IDLE;
            default:  st_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      fl_we    = 1'b0;
      fl_re    = 1'b0;
      fl_wdata = CMD_ARRAY;
      fl_addr  = addr_q;
      case (st_q)
         S_PRE_FF: fl_we = 1'b1;
         S_CMD_A: begin
            fl_we    = 1'b1;
            fl_wdata = (op_q == OP_ERASE) ? CMD_ERS_SET : CMD_PROG;
         end
         S_CMD_B: begin
            fl_we    = 1'b1;
            fl_wdata = (op_q == OP_ERASE) ? CMD_ERS_GO : data_q;
         end
         S_PCMD: begin
            fl_we    = 1'b1;
            fl_wdata = CMD_STAT;
         end
         S_CLR: begin
            fl_we    = 1'b1;
            fl_wdata = CMD_CLEAR;
         end
         S_ID_CMD: begin
            fl_we    = 1'b1;
            fl_wdata = CMD_IDENT;
         end
         S_PRD, S_ID_RD0: fl_re = 1'b1;
         S_ID_RD1: begin
            fl_re   = 1'b1;
            fl_addr = addr_q | ODD_OFS;
         end
         S_FIN_FF: fl_we = 1'b1;
         default: ;
      endcase
   end

   assign busy     = (st_q != S_IDLE);
   assign done     = (st_q == S_DONE);
   assign pass     = pass_q;
   assign err_code = err_q;

endmodule

// File: rtl/flseq_chk.sv
module flseq_chk #(
   parameter int BLOCK_AW = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic [1:0]          req_op,
   input logic                busy,
   input logic                done,
   input logic                pass,
   input logic [2:0]          err_code,
   input logic [BLOCK_AW-1:0] fl_addr_lo,
   input logic [7:0]          fl_wdata,
   input logic                fl_we,
   input logic                fl_re
);
   logic [1:0] op_t;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 op_t <= 2'd0;
      else if (req_valid && !busy) op_t <= req_op;
   end

   // R12
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fl_we, fl_re}));

   // R9
   done_after_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(fl_we && fl_wdata == 8'hFF));

   // R9
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R2
   erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && op_t == 2'd1 && fl_we) |-> (fl_addr_lo == '0));

   // R3
   read_after_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_re && op_t != 2'd2) |-> $past(fl_we && fl_wdata == 8'h70));

   // R7
   fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !pass) |-> (err_code != 3'd0));

   // R7
   pass_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pass) |-> (err_code == 3'd0));

endmodule

bind flash_prog_seq flseq_chk #(.BLOCK_AW(BLOCK_AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .busy       (busy),
   .done       (done),
   .pass       (pass),
   .err_code   (err_code),
   .fl_addr_lo (fl_addr[BLOCK_AW-1:0]),
   .fl_wdata   (fl_wdata),
   .fl_we      (fl_we),
   .fl_re      (fl_re)
);

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 20;
   localparam int BAW   = 16;
   localparam int DIV   = 3;
   localparam int LIMIT = 20;
   localparam logic [AW-1:0] BMASK = 20'hF0000;

   typedef struct packed {
      logic [1:0]  op;
      logic [19:0] addr;
      logic [7:0]  data;
      logic [7:0]  stat;
      logic [7:0]  bsy;
      logic        idbad;
      logic        xpass;
      logic [2:0]  xcode;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 20'h01234, 8'h5A, 8'h80, 8'd2,   1'b0, 1'b1, 3'd0}, // R4 clean program
      '{2'd0, 20'h00010, 8'h11, 8'h90, 8'd0,   1'b0, 1'b0, 3'd2}, // R4 R7 write err
      '{2'd0, 20'h7FFFF, 8'h00, 8'h98, 8'd1,   1'b0, 1'b0, 3'd4}, // R7 vpp beats write
      '{2'd0, 20'h40002, 8'hC3, 8'hA0, 8'd0,   1'b0, 1'b1, 3'd0}, // R4 bit5 ignored
      '{2'd1, 20'h34567, 8'h00, 8'h80, 8'd3,   1'b0, 1'b1, 3'd0}, // R5 clean erase
      '{2'd1, 20'h2FFFF, 8'h00, 8'hB0, 8'd0,   1'b0, 1'b0, 3'd3}, // R5 bits 5+4
      '{2'd1, 20'h10001, 8'h00, 8'h90, 8'd0,   1'b0, 1'b1, 3'd0}, // R5 bit4 alone
      '{2'd1, 20'h9ABCD, 8'h00, 8'hA8, 8'd1,   1'b0, 1'b0, 3'd4}, // R7 vpp beats erase
      '{2'd1, 20'h55555, 8'h00, 8'hA0, 8'd0,   1'b0, 1'b0, 3'd3}, // R7 erase err
      '{2'd0, 20'h00ABC, 8'h77, 8'h80, 8'd255, 1'b0, 1'b0, 3'd1}, // R6 program timeout
      '{2'd1, 20'hF1234, 8'h00, 8'h88, 8'd255, 1'b0, 1'b0, 3'd1}, // R6 erase timeout
      '{2'd2, 20'h51234, 8'h00, 8'h80, 8'd0,   1'b0, 1'b1, 3'd0}, // R10 id good
      '{2'd2, 20'h6FFFF, 8'h00, 8'h80, 8'd0,   1'b1, 1'b0, 3'd6}, // R10 id bad
      '{2'd3, 20'h00777, 8'h00, 8'h80, 8'd0,   1'b0, 1'b1, 3'd0}  // R13 read mode
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          busy, done, pass;
   logic [2:0]    err_code;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_wdata;
   logic          fl_we, fl_re;
   logic [7:0]    fl_rdata;
   logic [7:0]    ovw_old = '0, ovw_new = '0;
   logic          ovw_ok;

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_prog_seq #(.AW(AW), .BLOCK_AW(BAW), .POLL_DIV(DIV), .POLL_LIMIT(LIMIT)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
      .pass(pass), .err_code(err_code), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
      .ovw_old(ovw_old), .ovw_new(ovw_new), .ovw_ok(ovw_ok));

   // flash device model
   logic        mdl_clr = 1'b0;
   logic [7:0]  cfg_stat = 8'h80;
   logic [7:0]  cfg_bsy  = 8'd0;
   logic        cfg_idbad = 1'b0;
   logic [1:0]  fmode;
   logic        cleared;
   logic [7:0]  busy_left;
   int          first_reads, wn, rn, cyc, last70, gap_bad;
   logic [AW-1:0] wa [64];
   logic [7:0]    wd [64];
   logic [AW-1:0] ra [4];

   assign fl_rdata = (fmode == 2'd1) ? (cleared ? 8'h80 : (busy_left != 0 ? 8'h00 : cfg_stat))
                   : (fmode == 2'd2) ? (fl_addr[0] ? 8'hA2 : (cfg_idbad ? 8'h88 : 8'h89))
                   : 8'hFF;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mdl_clr) begin
         fmode <= 2'd0; cleared <= 1'b0; busy_left <= cfg_bsy;
         first_reads <= 0; wn <= 0; rn <= 0; last70 <= -1; gap_bad <= 0;
      end else begin
         if (fl_we) begin
            if (wn < 64) begin wa[wn] <= fl_addr; wd[wn] <= fl_wdata; end
            wn <= wn + 1;
            case (fl_wdata)
               8'hFF: fmode <= 2'd0;
               8'h70: fmode <= 2'd1;
               8'h90: fmode <= 2'd2;
               8'h50: cleared <= 1'b1;
               default: ;
            endcase
            if (fl_wdata == 8'h70 && !cleared) begin
               if (last70 >= 0 && (cyc - last70) != DIV + 2) gap_bad <= gap_bad + 1;
               last70 <= cyc;
            end
         end
         if (fl_re) begin
            if (rn < 4) ra[rn] <= fl_addr;
            rn <= rn + 1;
            if (fmode == 2'd1 && !cleared) begin
               first_reads <= first_reads + 1;
               if (busy_left != 0 && busy_left != 8'd255) busy_left <= busy_left - 1;
            end
         end
      end
   end

   initial cyc = 0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      logic [AW-1:0] ta;
      int n;
      cfg_stat = v.stat; cfg_bsy = v.bsy; cfg_idbad = v.idbad;
      mdl_clr = 1'b1;
      @(negedge clk);
      mdl_clr = 1'b0;
      req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      chk(done, "R9 done seen", {31'd0, done}, 32'd1);
      ta = (v.op == 2'd1 || v.op == 2'd2) ? (v.addr & BMASK) : v.addr;
      chk(pass == v.xpass, "R4/R5 pass flag", {31'd0, pass}, {31'd0, v.xpass});
      chk(err_code == v.xcode, "R7 err_code", {29'd0, err_code}, {29'd0, v.xcode});
      chk(wa[wn-1] == ta && wd[wn-1] == 8'hFF, "R9 final 0xFF write",
          {4'd0, wa[wn-1], wd[wn-1]}, {4'd0, ta, 8'hFF});
      case (v.op)
         2'd0: begin
            chk(wd[0] == 8'hFF && wd[1] == 8'h40 && wd[2] == v.data, "R1 program bytes",
                {8'd0, wd[0], wd[1], wd[2]}, {8'd0, 8'hFF, 8'h40, v.data});
            chk(wa[0] == ta && wa[1] == ta && wa[2] == ta, "R1 program address",
                {12'd0, wa[2]}, {12'd0, ta});
         end
         2'd1: begin
            chk(wd[0] == 8'h20 && wd[1] == 8'hD0, "R2 erase bytes",
                {16'd0, wd[0], wd[1]}, {16'd0, 8'h20, 8'hD0});
            chk(wa[0] == ta && wa[1] == ta, "R2 erase aligned address",
                {12'd0, wa[1]}, {12'd0, ta});
         end
         2'd2: begin
            chk(wd[0] == 8'h90 && wa[0] == ta, "R10 ident command",
                {4'd0, wa[0], wd[0]}, {4'd0, ta, 8'h90});
            chk(rn == 2 && ra[0] == ta && ra[1] == (ta | 20'd1), "R10 ident reads",
                {12'd0, ra[1]}, {12'd0, ta | 20'd1});
         end
         default: chk(wn == 1 && rn == 0, "R13 read mode single write", wn, 32'd1);
      endcase
      if (v.op < 2'd2) begin
         chk(cleared, "R8 status clear written", {31'd0, cleared}, 32'd1);
         chk(wd[wn-2] != 8'h50 && wd[wn-3] == 8'h50, "R8 second poll after clear",
             {24'd0, wd[wn-3]}, 32'h50);
         chk(gap_bad == 0, "R3 poll spacing", gap_bad, 32'd0);
         if (v.bsy == 8'd255)
            chk(first_reads == LIMIT, "R6 R3 poll limit reads", first_reads, LIMIT);
         else
            chk(first_reads == v.bsy + 1, "R3 polls until ready", first_reads, v.bsy + 1);
      end
      @(negedge clk);
      chk(!busy, "R9 idle after done", {31'd0, busy}, 32'd0);
   endtask

   task automatic ovw(input logic [7:0] o, input logic [7:0] nw);
      logic expv;
      ovw_old = o; ovw_new = nw;
      #1;
      expv = ((~o & nw) == 8'h00);
      chk(ovw_ok == expv, "R11 overwrite check", {31'd0, ovw_ok}, {31'd0, expv});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !fl_we && !fl_re, "R12 reset outputs",
          {28'd0, busy, done, fl_we, fl_re}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !fl_we, "R12 idle after reset", {30'd0, busy, fl_we}, 32'd0);
      for (int i = 0; i < NV; i++) run_vec(VECS[i]);
      ovw(8'hF0, 8'h30);
      ovw(8'h0F, 8'h10);
      ovw(8'h00, 8'h00);
      ovw(8'hFF, 8'hA5);
      ovw(8'hA5, 8'hA5);
      ovw(8'hA5, 8'hA7);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule